// File: doc/BRIEF.md
# Compare-Match Watchdog Timer

This unit supervises a small microcontroller. A prescaler divides the system clock by a selectable power of two. An 8-bit interval counter counts the divided ticks. Each time that counter wraps from its top value to zero, a 6-bit supervision counter advances once. A comparator checks the supervision counter against a programmed 6-bit limit. The two counters therefore form a slow chain of timers. The supervision counter is never clocked by the system clock directly.

A match is a "trip event". One mode bit decides what a trip event does. In timer mode it pulses an interrupt request, and it does so again every (limit + 1) wraps of the interval counter. In supervisor mode it raises a reset request that holds until the system reset returns. Software prevents the trip by writing the clear bit of the supervision register before the limit is reached. Software reaches the unit through a byte-wide port with two addresses. A write to address 0 sets the control fields. A read from address 0 returns the live interval count.

The trip logic is a two-state machine. **ST_ARMED** is the counting state. The transition **TRIP** (a trip event while the mode bit is 1) moves it to **ST_TRIPPED**. ST_TRIPPED has a single transition, **HOLD**, back to itself. Only the reset input leaves it. When a trip event occurs in timer mode, the machine stays in ST_ARMED and produces one interrupt pulse.

Top module: `wdt_unit`

## Requirements
- R1: After `rst_n` is low, `irq` and `rst_req` are 0, a read of address 0 returns 0, all control fields are 0 (timer mode, prescaler stopped), the limit is 0 and both counters are 0.
- R2: In a control write (address 0), bits 2:0 select the prescaler ratio 2^(select+1) and bit 4 enables the prescaler. While bit 4 is 0 the interval count does not change.
- R3: The interval counter is 8 bits wide and advances once per prescaler tick. A read of address 0 returns it. Its wrap from 255 to 0 is a one-cycle overflow that advances the supervision counter.
- R4: The supervision counter advances once per overflow. If it already equals the limit (bits 5:0 of a write to address 1), the next overflow takes it to 0. Trip events are therefore (limit + 1) overflows apart.
- R5: In timer mode (control bit 5 = 0), each trip event gives a one-cycle `irq` pulse in the cycle after the overflow edge. Its period is exactly (limit + 1) × 256 × 2^(select+1) clocks.
- R6: In supervisor mode (control bit 5 = 1), a trip event makes `rst_req` 1, and it stays 1 until `rst_n` goes low. `irq` stays 0 while `rst_req` is 1.
- R7: Writing 1 to bit 6 at address 1 zeroes the supervision counter one cycle after the write. The bit then clears itself. If the counter is cleared often enough, no trip event occurs.
- R8: Writing 1 to bit 3 at address 0 zeroes the interval counter one cycle after the write. The bit then clears itself. This clear leaves the supervision counter unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 1 | 0 = control / interval count, 1 = supervision register |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Interval count when bus_addr is 0, else 0 |
| irq | output | 1 | Periodic interrupt pulse (timer mode) |
| rst_req | output | 1 | Sticky reset request (supervisor mode) |

## Verification
A wrong supervision count does not show at once. It shows as an `irq` pulse that arrives one or more overflows early or late, which is hundreds of clocks after the fault. For that reason, trip times are checked against exact cycle windows taken from R5, not by looking for the presence of a pulse. A clear that reaches the wrong counter shows up the same way: it moves the next interrupt by about half a period. The bench places an interval clear in the middle of a period to expose this. A state machine stuck in, or leaving, ST_TRIPPED shows in `rst_req` within one cycle. The bench checks `rst_req` over thousands of cycles and after a later supervision clear.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    // Bit positions the register decoders rely on.
    localparam int CTL_MODE_BIT = 5;
    localparam int CTL_EN_BIT   = 4;
    localparam int CTL_ICLR_BIT = 3;
    localparam int WD_CLR_BIT   = 6;

    localparam logic ADDR_CTL = 1'b0;
    localparam logic ADDR_WD  = 1'b1;

    typedef enum logic {
        ST_ARMED   = 1'b0,
        ST_TRIPPED = 1'b1
    } wd_state_t;
endpackage

// File: rtl/wdt_prescale.sv
module wdt_prescale #(
    parameter int PW = 8,
    parameter int SW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [SW-1:0] sel,
    output logic          tick
);
    logic [PW-1:0] pre;
    logic [PW-1:0] mask;

    // Mask of the low (sel + 1) bits; the tick fires when all of them are 1.
    always_comb begin
        for (int i = 0; i < PW; i++) begin
            mask[i] = (i <= int'(sel));
        end
        tick = en && ((pre & mask) == mask);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre <= '0;
        end else if (en) begin
            pre <= pre + 1'b1;
        end
    end
endmodule

// File: rtl/wdt_interval.sv
module wdt_interval #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          tclr,
    output logic [TW-1:0] cnt,
    output logic          ovf
);
    assign ovf = tick && !tclr && (&cnt);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (tclr) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/wdt_watch.sv
module wdt_watch
    import wdt_pkg::*;
#(
    parameter int WW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ovf,
    input  logic          wclr,
    input  logic          mode,
    input  logic [WW-1:0] limit,
    output logic [WW-1:0] cnt,
    output logic          irq,
    output logic          rst_req
);
    logic [WW-1:0] nxt;
    logic          hit;
    wd_state_t     st, st_n;

    // Wrap after the matching value, and flag the step that lands on the limit.
    always_comb begin
        nxt = (cnt == limit) ? '0 : cnt + 1'b1;
        hit = ovf && !wclr && (nxt == limit);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (wclr) begin
            cnt <= '0;
        end else if (ovf) begin
            cnt <= nxt;
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_ARMED;
        end else begin
            st <= st_n;
        end
    end

    // Transitions: TRIP (ARMED -> TRIPPED), HOLD (TRIPPED -> TRIPPED).
    always_comb begin
        st_n = st;
        unique case (st)
            ST_ARMED:   if (hit && mode) st_n = ST_TRIPPED;
            ST_TRIPPED: st_n = ST_TRIPPED;
        endcase
    end

    // Outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq     <= 1'b0;
            rst_req <= 1'b0;
        end else begin
            irq     <= (st == ST_ARMED) && hit && !mode;
            rst_req <= (st_n == ST_TRIPPED);
        end
    end
endmodule

// File: rtl/wdt_unit.sv
module wdt_unit
    import wdt_pkg::*;
#(
    parameter int TW = 8,
    parameter int WW = 6,
    parameter int SW = 3,
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_addr,
    input  logic          bus_wr,
    input  logic [TW-1:0] bus_wdata,
    output logic [TW-1:0] bus_rdata,
    output logic          irq,
    output logic          rst_req
);
    logic          mode_q, en_q, tclr_q, wclr_q;
    logic [SW-1:0] sel_q;
    logic [WW-1:0] limit_q;
    logic          tick_w, ovf_w;
    logic [TW-1:0] tcnt_w;
    logic [WW-1:0] wcnt_w;
    logic          unused_wdata;

    assign unused_wdata = bus_wdata[TW-1];

    // Register writes; both clear bits last a single cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= 1'b0;
            en_q    <= 1'b0;
            sel_q   <= '0;
            limit_q <= '0;
            tclr_q  <= 1'b0;
            wclr_q  <= 1'b0;
        end else begin
            tclr_q <= 1'b0;
            wclr_q <= 1'b0;
            if (bus_wr) begin
                if (bus_addr == ADDR_CTL) begin
                    mode_q <= bus_wdata[CTL_MODE_BIT];
                    en_q   <= bus_wdata[CTL_EN_BIT];
                    sel_q  <= bus_wdata[SW-1:0];
                    tclr_q <= bus_wdata[CTL_ICLR_BIT];
                end else begin
                    limit_q <= bus_wdata[WW-1:0];
                    wclr_q  <= bus_wdata[WD_CLR_BIT];
                end
            end
        end
    end

    assign bus_rdata = (bus_addr == ADDR_CTL) ? tcnt_w : '0;

    wdt_prescale #(.PW(PW), .SW(SW)) u_pre (
        .clk(clk), .rst_n(rst_n), .en(en_q), .sel(sel_q), .tick(tick_w)
    );

    wdt_interval #(.TW(TW)) u_ivl (
        .clk(clk), .rst_n(rst_n), .tick(tick_w), .tclr(tclr_q),
        .cnt(tcnt_w), .ovf(ovf_w)
    );

    wdt_watch #(.WW(WW)) u_wd (
        .clk(clk), .rst_n(rst_n), .ovf(ovf_w), .wclr(wclr_q), .mode(mode_q),
        .limit(limit_q), .cnt(wcnt_w), .irq(irq), .rst_req(rst_req)
    );
endmodule

module wdt_unit_chk #(
    parameter int TW = 8,
    parameter int WW = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          irq,
    input logic          rst_req,
    input logic          ovf,
    input logic          wclr,
    input logic [TW-1:0] tcnt,
    input logic [WW-1:0] wcnt
);
    p_irq_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);
    p_irq_after_ovf_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(ovf));
    p_rst_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> rst_req);
    p_no_irq_tripped_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> !rst_req);
    p_wcnt_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(wcnt) |-> $past(ovf || wclr));
    p_ovf_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> (tcnt == '0));
    p_wclr_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wclr |=> (wcnt == '0));
endmodule

bind wdt_unit wdt_unit_chk #(.TW(TW), .WW(WW)) u_chk (
    .clk(clk), .rst_n(rst_n), .irq(irq), .rst_req(rst_req), .ovf(ovf_w),
    .wclr(wclr_q), .tcnt(tcnt_w), .wcnt(wcnt_w)
);

// File: tb/wdt_unit_test.sv
module wdt_unit_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_addr = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       irq, rst_req;

    int     n_chk = 0;
    int     n_bad = 0;
    int     n_irq = 0;
    longint cyc = 0;
    longint last_irq = 0;
    logic   irq_prev = 1'b0;

    typedef struct {
        longint lo;
        longint hi;
        string  tag;
    } win_t;
    win_t exp_q[$];

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    wdt_unit uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .rst_req(rst_req)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic a, input logic [7:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr   = 1'b0;
        bus_addr = 1'b0;
    endtask

    function automatic logic [7:0] ctl(input bit mode, input bit en, input bit iclr, input int sel);
        return {2'b00, mode, en, iclr, 3'(sel)};
    endfunction

    // Stop, zero both counters, program the limit, then start.
    task automatic setup(input bit mode, input int sel, input int lim);
        bus_write(1'b0, ctl(mode, 1'b0, 1'b1, sel));
        bus_write(1'b1, 8'h40 | 8'(lim));
        bus_write(1'b0, ctl(mode, 1'b1, 1'b0, sel));
    endtask

    task automatic expect_irq(input longint lo, input longint hi, input string tag);
        win_t w;
        w.lo = lo; w.hi = hi; w.tag = tag;
        exp_q.push_back(w);
    endtask

    // Scoreboard monitor: every irq pulse must match the front window.
    always @(negedge clk) begin
        if (rst_n) begin
            if (irq && irq_prev)
                chk(1'b0, "R5 irq wider than one cycle", 2, 1);
            if (irq) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R5/R7 unexpected irq at cycle", cyc, -1);
                end else begin
                    win_t w;
                    w = exp_q.pop_front();
                    chk(cyc >= w.lo && cyc <= w.hi, w.tag, cyc, w.lo);
                end
                last_irq = cyc;
                n_irq++;
            end
        end
        irq_prev = irq;
    end

    initial begin
        longint t0, k, tr;
        int base;
        logic [7:0] a, b;

        repeat (4) @(negedge clk);
        chk(irq == 1'b0, "R1 irq after reset", irq, 0);
        chk(rst_req == 1'b0, "R1 rst_req after reset", rst_req, 0);
        chk(bus_rdata == 8'h00, "R1 count after reset", bus_rdata, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(bus_rdata == 8'h00, "R1 R2 prescaler stopped after reset", bus_rdata, 0);

        // Timer mode, select 0, limit 2: trips 1536 clocks apart (R5, R4).
        setup(1'b0, 0, 2);
        t0 = cyc; base = n_irq;
        expect_irq(t0 + 1024 - 16, t0 + 1024 + 16, "R4 first trip after 2 overflows");
        wait (n_irq == base + 1);
        expect_irq(last_irq + 1536, last_irq + 1536, "R5 period limit2 sel0");
        expect_irq(last_irq + 3072, last_irq + 3072, "R5 period limit2 sel0 second");
        wait (n_irq == base + 3);
        chk(rst_req == 1'b0, "R5 no reset request in timer mode", rst_req, 0);

        // Select 2, limit 0: one trip per overflow, 2048 clocks (R2).
        setup(1'b0, 2, 0);
        t0 = cyc; base = n_irq;
        expect_irq(t0 + 2048 - 24, t0 + 2048 + 24, "R2 first trip sel2");
        wait (n_irq == base + 1);
        expect_irq(last_irq + 2048, last_irq + 2048, "R2 period sel2 limit0");
        expect_irq(last_irq + 4096, last_irq + 4096, "R2 period sel2 limit0 second");
        wait (n_irq == base + 3);

        // Supervision clears before the limit keep the trip away (R7).
        setup(1'b0, 0, 3);
        base = n_irq;
        for (int i = 0; i < 6; i++) begin
            repeat (1000) @(negedge clk);
            bus_write(1'b1, 8'h43);
        end
        chk(n_irq == base, "R7 no trip while cleared", n_irq - base, 0);
        k = cyc;
        expect_irq(k + 1000, k + 1600, "R7 trip resumes after clears stop");
        wait (n_irq == base + 1);

        // Interval clear in mid-period must not reset the supervision count (R8).
        setup(1'b0, 0, 1);
        t0 = cyc; base = n_irq;
        expect_irq(t0 + 512 - 16, t0 + 512 + 16, "R4 first trip limit1");
        wait (n_irq == base + 1);
        tr = last_irq;
        repeat (100) @(negedge clk);
        bus_write(1'b0, ctl(1'b0, 1'b1, 1'b1, 0));
        expect_irq(tr + 1000, tr + 1200, "R8 interval clear keeps supervision count");
        wait (n_irq == base + 2);

        // Prescaler off freezes the count; the interval clear zeroes it (R2, R8, R3).
        bus_write(1'b0, ctl(1'b0, 1'b0, 1'b0, 0));
        @(negedge clk);
        a = bus_rdata;
        repeat (50) @(negedge clk);
        b = bus_rdata;
        chk(a == b, "R2 count frozen while prescaler off", b, a);
        bus_write(1'b0, ctl(1'b0, 1'b0, 1'b1, 0));
        @(negedge clk);
        chk(bus_rdata == 8'h00, "R8 R3 interval clear reads back 0", bus_rdata, 0);

        // Supervisor mode, limit 1: sticky reset request (R6).
        setup(1'b1, 0, 1);
        t0 = cyc; base = n_irq;
        for (int i = 0; i < 2000; i++) begin
            if (rst_req) break;
            @(negedge clk);
        end
        chk(rst_req && cyc >= t0 + 512 - 16 && cyc <= t0 + 512 + 16,
            "R6 reset request time", cyc, t0 + 512);
        repeat (3000) @(negedge clk);
        chk(rst_req == 1'b1, "R6 reset request held", rst_req, 1);
        bus_write(1'b1, 8'h41);
        repeat (4) @(negedge clk);
        chk(rst_req == 1'b1, "R6 supervision clear does not drop request", rst_req, 1);
        chk(n_irq == base, "R6 no irq in supervisor mode", n_irq - base, 0);

        // Reset returns everything to its initial state (R1).
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(rst_req == 1'b0, "R1 rst_req cleared by reset", rst_req, 0);
        chk(irq == 1'b0, "R1 irq low in reset", irq, 0);
        chk(bus_rdata == 8'h00, "R1 count zero in reset", bus_rdata, 0);
        chk(exp_q.size() == 0, "R5 all expected trips seen", exp_q.size(), 0);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "R5 watchdog expired, run hung", cyc, 0);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule